// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Array

This block is a programmable AND plane feeding a fixed OR plane. Twelve dedicated inputs and ten feedback signals are each expanded into a true line and a complement line. That gives 44 array lines, and every product term may connect to any of them. A configuration store holds one 44-bit connection row for each of the 133 product terms.

Of the 133 terms, 120 are collected into ten OR sums of unequal width. Ten more act as per-output enable terms. The last three are global terms for a synchronous preset, an asynchronous clear and a clock. Every output of the array is a purely combinational function of the inputs and the stored rows. Nothing downstream of the array is part of this block: no flip-flops, no polarity selection and no pin drivers.

Rows are loaded through a valid/ready write port, one row per accepted cycle. Back-pressure is simple. `cfg_ready` is low only in a cycle where `erase_req` is high, and a row is taken on a rising clock edge when both `cfg_valid` and `cfg_ready` are high. The sender holds the address and data stable until that edge. A one-cycle erase request opens every connection in the whole store.

Top module: `sop_array`

## Requirements
- R1: Array line 2*i carries signal i and line 2*i+1 carries its inverse. Signals 0..11 are `ded_in[0..11]` and signals 12..21 are `fb_in[0..9]`. In a stored row, bit j set to 1 connects line j to that product term.
- R2: A product term is the AND of every line it is connected to. A term whose row is all zeros (every connection open) evaluates to 1.
- R3: A term connected to both lines of any one signal evaluates to 0 for all inputs, so it contributes nothing to its OR sum.
- R4: Output `sum_out[k]` is the OR of a contiguous run of product terms. The run sizes for k=0..9 are 8,10,12,14,16,16,14,12,10,8, and the runs are laid out back to back from term index 0 through 119.
- R5: Term 120+k drives `oe_out[k]`. Term 130 drives `preset_term`, term 131 drives `clear_term` and term 132 drives `clock_term`.
- R6: When `cfg_valid` and `cfg_ready` are both high at a rising edge of `clk`, `cfg_data` replaces the row at `cfg_addr`. Outputs reflect the new row from that edge on, and the store changes at no other time except on erase or reset.
- R7: A write to an address of 133 or above leaves every stored row unchanged.
- R8: While `erase_req` is high, `cfg_ready` is low. At the rising edge with `erase_req` high, every row becomes all zeros, so all 133 terms evaluate to 1. Erase takes priority over a pending write.
- R9: While `rst_n` is low, every row is held at all zeros, so every output is 1.
- R10: Outputs follow changes on `ded_in` and `fb_in` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Asynchronous active-low reset; erases the store |
| erase_req | input | 1 | Opens every connection at the next rising edge |
| cfg_valid | input | 1 | A connection row is offered |
| cfg_ready | output | 1 | The store can take a row this cycle |
| cfg_addr | input | 8 | Product-term index of the offered row |
| cfg_data | input | 44 | Connection row, bit j for array line j |
| ded_in | input | 12 | Dedicated inputs |
| fb_in | input | 10 | Feedback inputs |
| sum_out | output | 10 | The ten OR sums |
| oe_out | output | 10 | Per-output enable terms |
| preset_term | output | 1 | Global synchronous-preset term |
| clear_term | output | 1 | Global asynchronous-clear term |
| clock_term | output | 1 | Clock product term |

## Verification
The embedded assertions check the following on every cycle:
- an all-open row evaluates true, and a row that connects both lines of one signal evaluates false;
- an accepted in-range write lands in the addressed row;
- an out-of-range write leaves the store unchanged;
- an erase clears every row;
- the outputs hold still when neither the inputs nor the store changed.

The line ordering, the grouping of terms into sums of unequal width and the roles of the last thirteen terms can only be shown by the bench. It loads random sparse rows, drives random inputs and compares every output with a model built from the requirements. The bench also covers directed cases: contradictory rows, erase racing a write, writes past the last index, and input changes made between clock edges.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned DED_N    = 12;
  localparam int unsigned OUT_N    = 10;
  localparam int unsigned SIG_N    = DED_N + OUT_N;
  localparam int unsigned LINE_N   = 2 * SIG_N;
  localparam int unsigned SUM_MIN  = 8;
  localparam int unsigned SUM_STEP = 2;
  localparam int unsigned CTRL_N   = 3;

  function automatic int unsigned run_size(int unsigned k);
    int unsigned m;
    m = (k < OUT_N / 2) ? k : (OUT_N - 1 - k);
    return SUM_MIN + SUM_STEP * m;
  endfunction

  function automatic int unsigned run_base(int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < k; i++) acc += run_size(i);
    return acc;
  endfunction

  localparam int unsigned SUM_TERMS = run_base(OUT_N);
  localparam int unsigned OE_BASE   = SUM_TERMS;
  localparam int unsigned CTRL_BASE = OE_BASE + OUT_N;
  localparam int unsigned PT_N      = CTRL_BASE + CTRL_N;
  localparam int unsigned ADDR_W    = $clog2(PT_N);
endpackage

// File: rtl/sop_lines.sv
module sop_lines
  import sop_pkg::*;
(
  input  logic [DED_N-1:0]  ded_in,
  input  logic [OUT_N-1:0]  fb_in,
  output logic [LINE_N-1:0] lines
);
  logic [SIG_N-1:0] sig;
  assign sig = {fb_in, ded_in};

  // R1: even line true, odd line inverse
  for (genvar i = 0; i < SIG_N; i++) begin : g_pair
    assign lines[2*i]   = sig[i];
    assign lines[2*i+1] = ~sig[i];
  end
endmodule

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
  import sop_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        erase_req,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [LINE_N-1:0]           wr_data,
  output logic [PT_N-1:0][LINE_N-1:0] rows
);
  logic in_range;
  assign in_range = wr_addr < ADDR_W'(PT_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows <= '0;
    end else if (erase_req) begin
      rows <= '0;
    end else if (wr_en && in_range) begin
      rows[wr_addr] <= wr_data;
    end
  end

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase_req && in_range) |=> rows[$past(wr_addr)] == $past(wr_data));

  assert_bad_addr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase_req && !in_range) |=> $stable(rows));

  assert_erase_opens_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> (rows == '0));
endmodule

// File: rtl/sop_pterm.sv
module sop_pterm
  import sop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_N-1:0] conn,
  input  logic [LINE_N-1:0] lines,
  output logic              hit
);
  // R2: an open connection is a don't-care input to the AND
  assign hit = &(lines | ~conn);

  logic [SIG_N-1:0] both_tied;
  for (genvar i = 0; i < SIG_N; i++) begin : g_tie
    assign both_tied[i] = conn[2*i] & conn[2*i+1];
  end

  assert_open_is_true_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (conn == '0) |-> hit);

  assert_contradiction_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|both_tied) |-> !hit);
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
  import sop_pkg::*;
(
  input  logic [PT_N-1:0]  terms,
  output logic [OUT_N-1:0] sum_out,
  output logic [OUT_N-1:0] oe_out,
  output logic             preset_term,
  output logic             clear_term,
  output logic             clock_term
);
  // R4: unequal contiguous runs per sum
  for (genvar k = 0; k < OUT_N; k++) begin : g_sum
    localparam int unsigned BASE = run_base(k);
    localparam int unsigned SIZE = run_size(k);
    assign sum_out[k] = |terms[BASE +: SIZE];
    // R5: dedicated enable term per output
    assign oe_out[k]  = terms[OE_BASE + k];
  end

  assign preset_term = terms[CTRL_BASE];
  assign clear_term  = terms[CTRL_BASE + 1];
  assign clock_term  = terms[CTRL_BASE + 2];
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_req,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LINE_N-1:0] cfg_data,
  input  logic [DED_N-1:0]  ded_in,
  input  logic [OUT_N-1:0]  fb_in,
  output logic [OUT_N-1:0]  sum_out,
  output logic [OUT_N-1:0]  oe_out,
  output logic              preset_term,
  output logic              clear_term,
  output logic              clock_term
);
  logic [LINE_N-1:0]           lines;
  logic [PT_N-1:0][LINE_N-1:0] rows;
  logic [PT_N-1:0]             terms;
  logic                        wr_en;

  assign cfg_ready = ~erase_req;
  assign wr_en     = cfg_valid & cfg_ready;

  sop_lines u_lines (
    .ded_in (ded_in),
    .fb_in  (fb_in),
    .lines  (lines)
  );

  sop_cfg_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .erase_req (erase_req),
    .wr_en     (wr_en),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_data),
    .rows      (rows)
  );

  for (genvar t = 0; t < PT_N; t++) begin : g_pt
    sop_pterm u_pt (
      .clk   (clk),
      .rst_n (rst_n),
      .conn  (rows[t]),
      .lines (lines),
      .hit   (terms[t])
    );
  end

  sop_or_plane u_or (
    .terms       (terms),
    .sum_out     (sum_out),
    .oe_out      (oe_out),
    .preset_term (preset_term),
    .clear_term  (clear_term),
    .clock_term  (clock_term)
  );

  assert_ready_drops_on_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> !cfg_ready);

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_valid) && !$past(erase_req) && $stable(ded_in) && $stable(fb_in))
      |-> ($stable(sum_out) && $stable(oe_out) && $stable(preset_term)
           && $stable(clear_term) && $stable(clock_term)));
endmodule

// File: tb/sop_array_tb.sv
module sop_array_tb;
  import sop_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 0;
  logic              rst_n = 0;
  logic              erase_req = 0;
  logic              cfg_valid = 0;
  logic              cfg_ready;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [LINE_N-1:0] cfg_data = '0;
  logic [DED_N-1:0]  ded_in = '0;
  logic [OUT_N-1:0]  fb_in = '0;
  logic [OUT_N-1:0]  sum_out, oe_out;
  logic              preset_term, clear_term, clock_term;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [43:0] model [133];

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_array u_dut (.*);

  function automatic logic [43:0] mk_lines(logic [11:0] d, logic [9:0] f);
    logic [43:0] l;
    for (int i = 0; i < 22; i++) begin
      logic s;
      s = (i < 12) ? d[i] : f[i-12];
      l[2*i] = s;
      l[2*i+1] = ~s;
    end
    return l;
  endfunction

  function automatic logic term_val(int t);
    return &(mk_lines(ded_in, fb_in) | ~model[t]);
  endfunction

  function automatic logic [9:0] exp_sums();
    int sizes [10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};
    int base = 0;
    logic [9:0] r = '0;
    for (int k = 0; k < 10; k++) begin
      for (int j = 0; j < sizes[k]; j++) r[k] |= term_val(base + j);
      base += sizes[k];
    end
    return r;
  endfunction

  function automatic logic [9:0] exp_oe();
    logic [9:0] r;
    for (int k = 0; k < 10; k++) r[k] = term_val(120 + k);
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    chk({ctx, " R4 sums"}, 64'(sum_out), 64'(exp_sums()));
    chk({ctx, " R5 enables"}, 64'(oe_out), 64'(exp_oe()));
    chk({ctx, " R5 preset"}, 64'(preset_term), 64'(term_val(130)));
    chk({ctx, " R5 clear"}, 64'(clear_term), 64'(term_val(131)));
    chk({ctx, " R5 clock"}, 64'(clock_term), 64'(term_val(132)));
  endtask

  task automatic wr(int addr, logic [43:0] data);
    @(negedge clk);
    cfg_valid = 1;
    cfg_addr = ADDR_W'(addr);
    cfg_data = data;
    @(negedge clk);
    cfg_valid = 0;
    if (addr < 133) model[addr] = data;
  endtask

  task automatic set_in(logic [11:0] d, logic [9:0] f);
    ded_in = d;
    fb_in = f;
    #1;
  endtask

  function automatic logic [43:0] sparse_row();
    logic [43:0] r = '0;
    for (int j = 0; j < 44; j++) r[j] = ($urandom % 9) == 0;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int t = 0; t < 133; t++) model[t] = '0;
    set_in(12'h5a3, 10'h2c1);
    #(CLK_PERIOD*3);
    // R9: in reset, all rows open -> all outputs 1
    chk("R9 sums in reset", 64'(sum_out), 64'h3ff);
    chk("R9 controls in reset", 64'({oe_out, preset_term, clear_term, clock_term}), 64'h1fff);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R9 after reset");

    // intact every row -> all false
    for (int t = 0; t < 133; t++) wr(t, '1);
    #1;
    check_all("R3 all intact");
    chk("R3 sums zero", 64'(sum_out), 64'h0);

    // R2: open one sum-term of output 3 (base 30)
    wr(35, '0);
    #1;
    chk("R2 open term lifts sum3", 64'(sum_out), 64'h008);
    // R1: term 0 tied to true of ded_in[2] (line 4) and complement of fb_in[1] (line 27)
    wr(0, 44'h1 << 4 | 44'h1 << 27);
    set_in(12'h004, 10'h000);
    chk("R1 line order hit", 64'(sum_out[0]), 64'h1);
    // R10: change input with no clock edge
    #3; set_in(12'h004, 10'h002);
    chk("R10 comb follow", 64'(sum_out[0]), 64'h0);
    set_in(12'h000, 10'h000);
    chk("R1 true line gates", 64'(sum_out[0]), 64'h0);
    // R3: both lines of fb_in[5] (lines 34,35) plus nothing else
    wr(0, 44'h3 << 34);
    set_in(12'hfff, 10'h020);
    chk("R3 contradiction", 64'(sum_out[0]), 64'h0);
    set_in(12'h000, 10'h000);
    chk("R3 contradiction low", 64'(sum_out[0]), 64'h0);
    // R5: enable term 127 and control terms on ded_in[0]
    wr(127, 44'h1);
    wr(130, 44'h2);
    wr(131, 44'h1);
    wr(132, 44'h2);
    set_in(12'h001, 10'h000);
    chk("R5 oe7", 64'(oe_out), 64'h080);
    chk("R5 preset/clear/clock", 64'({preset_term, clear_term, clock_term}), 64'b010);
    set_in(12'h000, 10'h000);
    chk("R5 flip", 64'({oe_out[7], preset_term, clear_term, clock_term}), 64'b0101);
    // R7: out-of-range writes
    wr(133, '0);
    wr(255, '0);
    check_all("R7 ignored");
    chk("R7 sums", 64'(sum_out), 64'h008);
    // R8: erase racing a write
    @(negedge clk);
    erase_req = 1;
    cfg_valid = 1;
    cfg_addr = 8'd5;
    cfg_data = '1;
    #1;
    chk("R8 ready low", 64'(cfg_ready), 64'h0);
    @(negedge clk);
    erase_req = 0;
    cfg_valid = 0;
    for (int t = 0; t < 133; t++) model[t] = '0;
    #1;
    chk("R8 ready back", 64'(cfg_ready), 64'h1);
    check_all("R8 erase");
    chk("R8 all ones", 64'({sum_out, oe_out, preset_term, clear_term, clock_term}), 64'h7fffff);

    // random rounds
    for (int round = 0; round < 6; round++) begin
      for (int t = 0; t < 133; t++) begin
        logic [43:0] r;
        r = (($urandom % 7) == 0) ? 44'hfff_ffff_ffff : sparse_row();
        wr(t, r);
      end
      for (int v = 0; v < 25; v++) begin
        @(negedge clk);
        set_in(12'($urandom), 10'($urandom));
        check_all("R6 random");
      end
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule